// File: doc/BRIEF.md
# Two-Phase Join/Fork Stage Controller

This block is one pipeline stage that sits where several upstream streams meet and several downstream streams leave. On its input side it joins a parameter-set number of source channels: each source announces a new item by toggling its request wire and holding its data word steady. The stage takes nothing until every source has toggled for the same item. It then captures all the source words together as one wide word and toggles a single completion signal. That completion signal is the acknowledge returned to every source and also the request sent to every destination.

On its output side the same stored word is fanned out to a parameter-set number of destinations. Each destination toggles its own acknowledge once it has taken the item. The stage opens for the next item only when every destination has acknowledged. The slowest branch therefore sets the pace, and no destination ever sees a word change under it.

All signalling uses transition form: one toggle per item on every wire, with no return to zero. The multi-way agreement on both sides comes from Muller C-elements, built here from clocked state logic. A channel is "ready" when its request and acknowledge levels are equal. It is "valid" when they differ. The back-pressure rule follows from that: a source must not change its data or toggle again while its request differs from its acknowledge.

Top module: `fj_fork_join`

## Requirements
- R1: Each C-element output moves to the common input level only when all of its inputs share that level; otherwise it keeps its last value. It starts at 0 after reset.
- R2: While reset is held (active-low `rst_n`), every source acknowledge, every destination request and the data output are 0.
- R3: No item is captured until every source has toggled its request for that item. A source that is ahead, or one that is alone, causes no change on any output.
- R4: The captured word is the concatenation of the source words, with source 0 in bits [W-1:0] and source s in bits [s*W+W-1:s*W]. The k-th output item combines the k-th item of every source, even when the sources run at unequal rates.
- R5: Each capture toggles every source acknowledge and every destination request exactly once, all in the same cycle.
- R6: While any destination has not yet acknowledged the current item, the data output holds and no further capture happens. The slowest destination throttles the stage.
- R7: Every destination receives every item exactly once, in source order.
- R8: The capture happens on the first rising clock edge at which all source requests differ from the stage state and all destination acknowledges equal it. Outputs change right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NSRC | Per-source request toggles |
| src_data | input | NSRC*W | Source words, source s at slice s |
| src_ack | output | NSRC | Per-source acknowledge toggles |
| dst_req | output | NDST | Per-destination request toggles |
| dst_data | output | NSRC*W | Joined word offered to all destinations |
| dst_ack | input | NDST | Per-destination acknowledge toggles |

## Verification
The bench targets the cases where one side runs ahead. A lone source toggles and is then held back for several cycles; a join that fired early would emit a word that mixes items from different positions. A fork is left with one destination acknowledged and the other not. A design that reopened on the first acknowledge would overwrite the word the slow branch has not taken yet. A random phase then runs the sources and the destinations at different rates and checks every delivered word against its index. This catches both lost and duplicated items, and pairings that slip by one.

// File: rtl/fj_pkg.sv
package fj_pkg;
  // width of the word formed by joining n sources of w bits each
  function automatic int join_bits(input int n, input int w);
    return n * w;
  endfunction
endpackage

// File: rtl/fj_celem.sv
module fj_celem #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in_i,
  output logic         out_o
);
  logic held_q;
  logic agree;

  assign agree = (in_i == '0) || (in_i == '1);

  always_comb out_o = agree ? in_i[0] : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= out_o;
  end

  // R1: output may only move to a level shared by all inputs
  p_change_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_o != $past(out_o)) |-> (in_i == {N{out_o}}));

  // R1: disagreeing inputs leave the output where it was
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_i != '0 && in_i != '1) |-> (out_o == $past(out_o)));
endmodule

// File: rtl/fj_stage.sv
module fj_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_i,
  input  logic [W-1:0] data_i,
  input  logic         ack_i,
  output logic         done_o,
  output logic [W-1:0] data_o
);
  logic         done_q;
  logic [W-1:0] data_q;
  logic         open_w;
  logic         take_w;

  // phase comparison: stage is open while completion equals downstream ack
  assign open_w = (done_q == ack_i);
  assign take_w = open_w && (req_i != done_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      data_q <= '0;
    end else if (take_w) begin
      done_q <= req_i;
      data_q <= data_i;
    end
  end

  assign done_o = done_q;
  assign data_o = data_q;

  // R6: an unacknowledged item is never overwritten
  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != ack_i) |=> (data_q == $past(data_q)));

  // R6: a stage awaiting acknowledges performs no capture
  p_throttle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != ack_i) |=> (done_q == $past(done_q)));

  // R5: each completion toggle follows a pending joined request
  p_toggle_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q != $past(done_q)) |-> ($past(req_i) == done_q));
endmodule

// File: rtl/fj_fork_join.sv
module fj_fork_join #(
  parameter int NSRC = 3,
  parameter int NDST = 2,
  parameter int W    = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [NSRC-1:0]                         src_req,
  input  logic [fj_pkg::join_bits(NSRC, W)-1:0]   src_data,
  output logic [NSRC-1:0]                         src_ack,
  output logic [NDST-1:0]                         dst_req,
  output logic [fj_pkg::join_bits(NSRC, W)-1:0]   dst_data,
  input  logic [NDST-1:0]                         dst_ack
);
  localparam int JW = fj_pkg::join_bits(NSRC, W);

  logic join_req;
  logic fork_ack;
  logic done;

  fj_celem #(.N(NSRC)) u_join_c (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  (src_req),
    .out_o (join_req)
  );

  fj_celem #(.N(NDST)) u_fork_c (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  (dst_ack),
    .out_o (fork_ack)
  );

  fj_stage #(.W(JW)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (join_req),
    .data_i (src_data),
    .ack_i  (fork_ack),
    .done_o (done),
    .data_o (dst_data)
  );

  assign src_ack = {NSRC{done}};
  assign dst_req = {NDST{done}};

  // R3: no source is acknowledged past its own request
  p_no_early_join_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ack[0] != $past(src_ack[0])) |-> ($past(src_req) == {NSRC{src_ack[0]}}));
endmodule

// File: tb/sim_fj_fork_join.sv
module sim_fj_fork_join;
  localparam int NSRC  = 3;
  localparam int NDST  = 2;
  localparam int W     = 8;
  localparam int JW    = NSRC * W;
  localparam int TOTAL = 300;
  localparam int LIMIT = 60000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NSRC-1:0] src_req;
  logic [JW-1:0]   src_data;
  logic [NSRC-1:0] src_ack;
  logic [NDST-1:0] dst_req;
  logic [JW-1:0]   dst_data;
  logic [NDST-1:0] dst_ack;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  fj_fork_join #(.NSRC(NSRC), .NDST(NDST), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_data(src_data),
    .src_ack(src_ack), .dst_req(dst_req), .dst_data(dst_data), .dst_ack(dst_ack)
  );

  function automatic logic [W-1:0] gen_word(input int s, input int k);
    return W'((k * 29 + s * 83 + 17) ^ (k >> 3));
  endfunction

  function automatic logic [JW-1:0] joined(input int k);
    logic [JW-1:0] v = '0;
    for (int s = 0; s < NSRC; s++) v[s*W +: W] = gen_word(s, k);
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_src(input int s, input int k);
    src_data[s*W +: W] = gen_word(s, k);
  endtask

  int sent  [NSRC];
  int recv  [NDST];
  logic [NDST-1:0] seen;
  logic [NDST-1:0] pend;
  int cyc;

  initial begin
    rst_n = 1'b0; src_req = '0; src_data = '0; dst_ack = '0;
    repeat (3) @(negedge clk);
    // R2: reset state
    check(src_ack == '0 && dst_req == '0, "R2 handshake reset", {src_ack, dst_req}, 0);
    check(dst_data == '0, "R2 data reset", dst_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: lone source toggles, nothing happens
    set_src(0, 0); src_req = 3'b001;
    repeat (4) @(negedge clk);
    check(dst_req == '0, "R3 lone source no request", dst_req, 0);
    check(src_ack == '0, "R3 lone source no ack", src_ack, 0);
    // remaining sources arrive in the same cycle
    set_src(1, 0); set_src(2, 0); src_req = 3'b111;
    @(negedge clk);
    check(dst_req == 2'b11, "R8 capture after one edge", dst_req, 2'b11);
    check(src_ack == 3'b111, "R5 all acks toggle", src_ack, 3'b111);
    check(dst_data == joined(0), "R4 joined word item 0", dst_data, joined(0));

    // R6: second item waits for the slow destination
    for (int s = 0; s < NSRC; s++) set_src(s, 1);
    src_req = 3'b000; dst_ack = 2'b01;
    repeat (4) @(negedge clk);
    check(dst_data == joined(0), "R6 data held for slow branch", dst_data, joined(0));
    check(src_ack == 3'b111 && dst_req == 2'b11, "R6 no capture while pending",
          {src_ack, dst_req}, {3'b111, 2'b11});
    dst_ack = 2'b11;
    @(negedge clk);
    check(dst_req == 2'b00, "R8 reopen after last ack", dst_req, 0);
    check(dst_data == joined(1), "R7 item 1 delivered", dst_data, joined(1));
    check(src_ack == 3'b000, "R5 acks toggle back", src_ack, 0);
    dst_ack = 2'b00;

    for (int s = 0; s < NSRC; s++) sent[s] = 2;
    for (int d = 0; d < NDST; d++) recv[d] = 2;
    seen = 2'b00; pend = 2'b00;
    void'($urandom(32'd1234));

    // random phase: unequal source and destination rates
    cyc = 0;
    while ((recv[0] < TOTAL || recv[1] < TOTAL) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      // observe destinations
      for (int d = 0; d < NDST; d++) begin
        if (dst_req[d] != seen[d]) begin
          check(dst_data == joined(recv[d]), "R4 R7 item order and pairing", dst_data, joined(recv[d]));
          check(dst_req == {NDST{dst_req[0]}}, "R5 destination requests together", dst_req, {NDST{dst_req[0]}});
          check(src_ack == {NSRC{dst_req[0]}}, "R5 source acks match", src_ack, {NSRC{dst_req[0]}});
          for (int s = 0; s < NSRC; s++)
            check(sent[s] > recv[d], "R3 all sources sent item", sent[s], recv[d]);
          seen[d] = dst_req[d];
          recv[d]++;
          pend[d] = 1'b1;
        end
      end
      if (pend != '0)
        check(dst_data == joined(recv[0] - 1), "R6 pending item stable", dst_data, joined(recv[0] - 1));
      // destinations acknowledge at different rates
      for (int d = 0; d < NDST; d++)
        if (pend[d] && ($urandom % (2 + 3 * d)) == 0) begin
          dst_ack[d] = seen[d];
          pend[d] = 1'b0;
        end
      // sources send at different rates
      for (int s = 0; s < NSRC; s++)
        if (sent[s] < TOTAL && src_ack[s] == src_req[s] && ($urandom % (1 + 2 * s)) == 0) begin
          set_src(s, sent[s]);
          src_req[s] = ~src_req[s];
          sent[s]++;
        end
    end
    if (cyc >= LIMIT) begin
      n_checks++; n_fail++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", recv[0], TOTAL);
    end
    check(recv[0] == TOTAL && recv[1] == TOTAL, "R7 all items delivered", recv[1], TOTAL);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule